// File: doc/BRIEF.md
# Comparator timer channel

A single timer channel that watches a shared, free-running main count and raises a one-clock fire strobe when that count equals the channel's compare value while counting is enabled. The channel runs in one of two modes. In one-shot mode the compare value stays where software put it. In periodic mode the compare value steps forward by a programmed period after each match, so that the channel keeps firing at a fixed interval.

Software reaches the channel through two write strobes that share a data bus with byte enables. One strobe is for the comparator word and one is for the configuration word. In periodic mode a comparator write always sets the period. It also reloads the compare value, but only while an arming bit in the configuration is set, and that arming bit clears itself on every comparator write. The main counter and the delivery of interrupts sit outside this block.

Top module: `cmp_timer_channel`

## Requirements
- R1: After a synchronous reset, `cmp_o` is 0xFFFFFFFF, `period_o` is 0, `cfg_o` is 0 and `fire_o` is 0.
- R2: `fire_o` is high for exactly the one cycle after a clock edge at which `count_en_i` is high and `count_i` equals `cmp_o`. It is low in every other cycle.
- R3: A clock edge at which `count_en_i` is low produces no fire and does not advance the compare value, even when `count_i` equals `cmp_o`.
- R4: In one-shot mode a comparator write merges byte lane k of `wdata_i` (bits 8k+7..8k) into the compare value for each set `wbe_i[k]`, keeps the other lanes, and leaves `period_o` unchanged. With `wbe_i` zero the write changes nothing.
- R5: A configuration write with `wbe_i[0]` set loads `wdata_i[0]` as the periodic-mode bit (`cfg_o[0]`, 1 = periodic) and `wdata_i[1]` as the arming bit (`cfg_o[1]`). With `wbe_i[0]` clear the write changes nothing.
- R6: In periodic mode a comparator write merges the data into the period, using the same lanes as in R4. It loads the compare value with the new period only if the arming bit was 1 before the write.
- R7: The arming bit is 0 after any comparator write. This holds in both modes, and also when a configuration write in the same cycle sets the arming bit.
- R8: Whenever the periodic-mode bit becomes or stays 0, the period is 0. This discards a period written in the same cycle.
- R9: A periodic match advances the compare value to the old value plus the smallest multiple of the period that lies strictly ahead of the count. At a match this is old value + period, modulo 2^32.
- R10: A one-shot match leaves the compare value unchanged. A compare value behind the count fires only once the count wraps around to it.
- R11: A comparator write in the same cycle as a match takes priority over the advance, and the fire strobe still occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| count_i | input | 32 | Shared main count value |
| count_en_i | input | 1 | Main count is running |
| cfg_we_i | input | 1 | Configuration word write strobe |
| cmp_we_i | input | 1 | Comparator word write strobe |
| wdata_i | input | 32 | Write data |
| wbe_i | input | 4 | Byte enables for write data |
| fire_o | output | 1 | One-cycle match strobe |
| cmp_o | output | 32 | Active compare value |
| period_o | output | 32 | Stored period |
| cfg_o | output | 2 | Configuration: bit 0 periodic mode, bit 1 arming bit |

## Verification
The compare value, period and configuration are exposed directly at the ports. A wrong register update therefore shows as a mismatch against the reference model on the very next cycle. A compare value that was advanced wrongly, or left unarmed, also shows up later: `fire_o` pulses at the wrong count, or fails to pulse at all. The bench jumps the count across the 2^32 wrap so that those late effects surface within a few dozen cycles, not billions.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

  // Configuration word layout (bit positions within byte lane 0)
  localparam int CFG_PERIODIC_BIT = 0;
  localparam int CFG_ARM_BIT      = 1;
  localparam int LANE_W           = 8;

  typedef struct packed {
    logic arm;
    logic periodic;
  } chan_cfg_t;

endpackage

// File: rtl/tmr_cfg_reg.sv
module tmr_cfg_reg
  import tmr_chan_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_we_i,
  input  logic       lane0_en_i,
  input  logic [1:0] cfg_bits_i,
  input  logic       cmp_we_i,
  output chan_cfg_t  cfg_q_o,
  output chan_cfg_t  cfg_d_o
);

  chan_cfg_t cfg_q;
  chan_cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_we_i && lane0_en_i) begin
      cfg_d.periodic = cfg_bits_i[CFG_PERIODIC_BIT];
      cfg_d.arm      = cfg_bits_i[CFG_ARM_BIT];
    end
    // any comparator write disarms, winning over a same-cycle config write
    if (cmp_we_i) cfg_d.arm = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else     cfg_q <= cfg_d;
  end

  assign cfg_q_o = cfg_q;
  assign cfg_d_o = cfg_d;

  // R7: the arming bit never survives a comparator write
  p_arm_cleared_r7: assert property (@(posedge clk) disable iff (rst)
    cmp_we_i |=> !cfg_q_o.arm);

endmodule

// File: rtl/tmr_cmp_reg.sv
module tmr_cmp_reg
  import tmr_chan_pkg::*;
#(
  parameter  int CNT_W = 32,
  localparam int LANES = CNT_W / LANE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [LANES-1:0] wbe_i,
  input  chan_cfg_t        cfg_q_i,
  input  logic             periodic_next_i,
  input  logic             advance_i,
  output logic [CNT_W-1:0] cmp_o,
  output logic [CNT_W-1:0] per_o
);

  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic [CNT_W-1:0] per_q, per_d;
  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] merged;

  // the write lands on the period in periodic mode, on the compare value otherwise
  assign base = cfg_q_i.periodic ? per_q : cmp_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged[g*LANE_W +: LANE_W] =
      wbe_i[g] ? wdata_i[g*LANE_W +: LANE_W] : base[g*LANE_W +: LANE_W];
  end

  always_comb begin
    cmp_d = cmp_q;
    per_d = per_q;
    if (cmp_we_i) begin
      if (cfg_q_i.periodic) begin
        per_d = merged;
        if (cfg_q_i.arm) cmp_d = merged;
      end else begin
        cmp_d = merged;
      end
    end else if (advance_i) begin
      // counter equals compare value at a match: next step is one period ahead
      cmp_d = cmp_q + per_q;
    end
    if (!periodic_next_i) per_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q <= '1;
      per_q <= '0;
    end else begin
      cmp_q <= cmp_d;
      per_q <= per_d;
    end
  end

  assign cmp_o = cmp_q;
  assign per_o = per_q;

  // R8: outside periodic mode the period register holds zero
  p_period_zero_r8: assert property (@(posedge clk) disable iff (rst)
    !cfg_q_i.periodic |-> (per_q == '0));

  // R4: a one-shot write with no lane enabled leaves the compare value alone
  p_no_lane_no_change_r4: assert property (@(posedge clk) disable iff (rst)
    (cmp_we_i && !cfg_q_i.periodic && (wbe_i == '0)) |=> $stable(cmp_q));

endmodule

// File: rtl/tmr_match.sv
module tmr_match #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] count_i,
  input  logic             count_en_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic             match_o,
  output logic             fire_o
);

  logic fire_q;

  assign match_o = count_en_i && (count_i == cmp_i);

  always_ff @(posedge clk) begin
    if (rst) fire_q <= 1'b0;
    else     fire_q <= match_o;
  end

  assign fire_o = fire_q;

  // R3: no strobe follows an edge with the count stopped
  p_no_fire_disabled_r3: assert property (@(posedge clk) disable iff (rst)
    !count_en_i |=> !fire_o);

endmodule

// File: rtl/cmp_timer_channel.sv
module cmp_timer_channel
  import tmr_chan_pkg::*;
#(
  parameter  int CNT_W = 32,
  localparam int LANES = CNT_W / LANE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] count_i,
  input  logic             count_en_i,
  input  logic             cfg_we_i,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [LANES-1:0] wbe_i,
  output logic             fire_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic [CNT_W-1:0] period_o,
  output logic [1:0]       cfg_o
);

  chan_cfg_t        cfg_q;
  chan_cfg_t        cfg_d;
  logic             match;
  logic             advance;
  logic [CNT_W-1:0] cmp_val;
  logic [CNT_W-1:0] per_val;

  tmr_cfg_reg u_cfg (
    .clk        (clk),
    .rst        (rst),
    .cfg_we_i   (cfg_we_i),
    .lane0_en_i (wbe_i[0]),
    .cfg_bits_i (wdata_i[1:0]),
    .cmp_we_i   (cmp_we_i),
    .cfg_q_o    (cfg_q),
    .cfg_d_o    (cfg_d)
  );

  tmr_match #(.CNT_W(CNT_W)) u_match (
    .clk        (clk),
    .rst        (rst),
    .count_i    (count_i),
    .count_en_i (count_en_i),
    .cmp_i      (cmp_val),
    .match_o    (match),
    .fire_o     (fire_o)
  );

  // a comparator write in the same cycle takes priority over stepping
  assign advance = match && cfg_q.periodic && !cmp_we_i;

  tmr_cmp_reg #(.CNT_W(CNT_W)) u_cmp (
    .clk             (clk),
    .rst             (rst),
    .cmp_we_i        (cmp_we_i),
    .wdata_i         (wdata_i),
    .wbe_i           (wbe_i),
    .cfg_q_i         (cfg_q),
    .periodic_next_i (cfg_d.periodic),
    .advance_i       (advance),
    .cmp_o           (cmp_val),
    .per_o           (per_val)
  );

  assign cmp_o    = cmp_val;
  assign period_o = per_val;
  assign cfg_o    = cfg_q;

  // R9: a periodic match moves the compare value exactly one period on
  p_periodic_step_r9: assert property (@(posedge clk) disable iff (rst)
    (count_en_i && (count_i == cmp_o) && cfg_o[0] && !cmp_we_i)
      |=> (cmp_o == CNT_W'($past(cmp_o) + $past(period_o))));

  // R10: a one-shot match keeps the compare value
  p_oneshot_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (count_en_i && (count_i == cmp_o) && !cfg_o[0] && !cmp_we_i)
      |=> $stable(cmp_o));

endmodule

// File: tb/test_cmp_timer_channel.sv
`timescale 1ns/1ps
module test_cmp_timer_channel;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] count_i = '0;
  logic        count_en_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic        cmp_we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [3:0]  wbe_i = '0;
  logic        fire_o;
  logic [31:0] cmp_o;
  logic [31:0] period_o;
  logic [1:0]  cfg_o;

  int errors = 0;
  int checks = 0;
  int fires  = 0;

  always #2.5 clk = ~clk;

  cmp_timer_channel i_cmp_timer_channel (
    .clk(clk), .rst(rst), .count_i(count_i), .count_en_i(count_en_i),
    .cfg_we_i(cfg_we_i), .cmp_we_i(cmp_we_i), .wdata_i(wdata_i), .wbe_i(wbe_i),
    .fire_o(fire_o), .cmp_o(cmp_o), .period_o(period_o), .cfg_o(cfg_o)
  );

  // behavioural reference model
  logic [31:0] m_cmp, m_per, n_cmp, n_per, mg;
  logic        m_mode, m_arm, m_fire, n_mode, n_arm, hit;

  always @(posedge clk) begin
    if (rst) begin
      m_cmp = 32'hFFFF_FFFF; m_per = 0; m_mode = 0; m_arm = 0; m_fire = 0;
    end else begin
      hit = count_en_i && (count_i == m_cmp);
      n_mode = m_mode; n_arm = m_arm; n_cmp = m_cmp; n_per = m_per;
      if (cfg_we_i && wbe_i[0]) begin
        n_mode = wdata_i[0];
        n_arm  = wdata_i[1];
      end
      if (cmp_we_i) n_arm = 0;
      if (cmp_we_i) begin
        mg = m_mode ? m_per : m_cmp;
        for (int k = 0; k < 4; k++)
          if (wbe_i[k]) mg[k*8 +: 8] = wdata_i[k*8 +: 8];
        if (m_mode) begin
          n_per = mg;
          if (m_arm) n_cmp = mg;
        end else begin
          n_cmp = mg;
        end
      end else if (hit && m_mode && m_per != 0) begin
        n_cmp = m_cmp + ((count_i - m_cmp) / m_per + 1) * m_per;
      end
      if (!n_mode) n_per = 0;
      m_fire = hit;
      m_cmp = n_cmp; m_per = n_per; m_mode = n_mode; m_arm = n_arm;
    end
  end

  task automatic check32(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic cyc(input string tag);
    @(posedge clk);
    @(negedge clk);
    check32({31'd0, fire_o}, {31'd0, m_fire}, {tag, " fire"});
    check32(cmp_o, m_cmp, {tag, " cmp"});
    check32(period_o, m_per, {tag, " period"});
    check32({30'd0, cfg_o}, {30'd0, m_arm, m_mode}, {tag, " cfg"});
    if (fire_o) fires++;
    cfg_we_i = 0; cmp_we_i = 0; wbe_i = 0; wdata_i = 0;
    if (count_en_i) count_i = count_i + 1;
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  task automatic wr_cmp(input logic [31:0] d, input logic [3:0] be, input string tag);
    cmp_we_i = 1; wdata_i = d; wbe_i = be;
    cyc(tag);
  endtask

  task automatic wr_cfg(input logic [31:0] d, input logic [3:0] be, input string tag);
    cfg_we_i = 1; wdata_i = d; wbe_i = be;
    cyc(tag);
  endtask

  initial begin
    #500000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    run(3, "R1");
    rst = 0;
    cyc("R1");
    check32(cmp_o, 32'hFFFF_FFFF, "R1 reset cmp");
    check32(period_o, 0, "R1 reset period");
    check32({30'd0, cfg_o}, 0, "R1 reset cfg");
    check32({31'd0, fire_o}, 0, "R1 reset fire");

    // one-shot lane writes
    wr_cmp(32'h0000_0040, 4'hF, "R4");
    check32(cmp_o, 32'h40, "R4 full write");
    wr_cmp(32'h0000_AB00, 4'b0010, "R4");
    check32(cmp_o, 32'h0000_AB40, "R4 lane 1 write");
    wr_cmp(32'h5555_5555, 4'h0, "R4");
    check32(cmp_o, 32'h0000_AB40, "R4 no lane");
    wr_cmp(32'h0000_0040, 4'hF, "R4");
    check32(period_o, 0, "R4 period untouched");

    // disabled count at the compare value
    count_i = 32'h40; count_en_i = 0; fires = 0;
    run(4, "R3");
    check32(fires, 0, "R3 fires while disabled");

    // one-shot match
    count_i = 32'h38; count_en_i = 1; fires = 0;
    run(16, "R2");
    check32(fires, 1, "R2 single strobe");
    check32(cmp_o, 32'h40, "R10 one-shot keeps cmp");

    // compare value behind the count: fires only after wrap
    count_en_i = 0;
    wr_cmp(32'h0000_0010, 4'hF, "R10");
    count_i = 32'h50; count_en_i = 1; fires = 0;
    run(8, "R10");
    check32(fires, 0, "R10 no fire behind count");
    count_i = 32'hFFFF_FFF8;
    run(32, "R10");
    check32(fires, 1, "R10 fire after wrap");

    // configuration writes
    count_en_i = 0;
    wr_cfg(32'hFFFF_FFFF, 4'b1110, "R5");
    check32({30'd0, cfg_o}, 0, "R5 lane 0 off");
    wr_cfg(32'h0000_0003, 4'b0001, "R5");
    check32({30'd0, cfg_o}, 3, "R5 periodic armed");

    // periodic comparator writes
    wr_cmp(32'h0000_0020, 4'hF, "R6");
    check32(cmp_o, 32'h20, "R6 armed load");
    check32(period_o, 32'h20, "R6 period");
    check32({30'd0, cfg_o}, 1, "R7 disarmed");
    wr_cmp(32'h0000_0030, 4'hF, "R6");
    check32(cmp_o, 32'h20, "R6 unarmed keeps cmp");
    check32(period_o, 32'h30, "R6 period update");

    // periodic stepping
    count_i = 32'h1C; count_en_i = 1; fires = 0;
    run(64, "R9");
    check32(fires, 2, "R9 two periodic fires");
    check32(cmp_o, 32'h80, "R9 stepped cmp");

    // stepping across the wrap
    count_en_i = 0;
    wr_cfg(32'h0000_0003, 4'h1, "R6");
    wr_cmp(32'hFFFF_FFF0, 4'hF, "R6");
    wr_cmp(32'h0000_0020, 4'hF, "R9");
    count_i = 32'hFFFF_FFEC; count_en_i = 1;
    run(8, "R9");
    check32(cmp_o, 32'h0000_0010, "R9 wrap step");

    // write in the same cycle as a match
    count_en_i = 0; count_i = 32'h10;
    count_en_i = 1;
    wr_cmp(32'h0000_0008, 4'hF, "R11");
    check32({31'd0, fire_o}, 1, "R11 fire kept");
    check32(cmp_o, 32'h10, "R11 no step");
    check32(period_o, 32'h8, "R11 period written");
    count_en_i = 0;

    // config arming and comparator write together
    cfg_we_i = 1;
    wr_cmp(32'h0000_0003, 4'h1, "R7");
    check32({30'd0, cfg_o}, 1, "R7 arm dropped");
    check32(period_o, 32'h3, "R7 period lane 0");

    // clearing periodic mode discards the period
    cfg_we_i = 1;
    wr_cmp(32'h0000_00F0, 4'h1, "R8");
    check32(period_o, 0, "R8 same-cycle period dropped");
    check32({30'd0, cfg_o}, 0, "R8 one-shot");
    wr_cfg(32'h1, 4'h1, "R8");
    wr_cmp(32'h44, 4'hF, "R8");
    check32(period_o, 32'h44, "R8 period set");
    wr_cfg(32'h0, 4'h1, "R8");
    check32(period_o, 0, "R8 period cleared");
    run(2, "R8");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule